// File: doc/BRIEF.md
# Memory Fill Engine

This block writes a repeating pattern over a byte range of memory once software starts it. Software loads a first byte address, a limit address and a pattern word through a small register port. It then writes the control word with its start bit set. The engine walks the range one aligned 32-bit word per beat. It drives byte enables so that only bytes inside the range are touched, and it rotates the pattern so that every byte lands at its proper offset from the first address.

The pattern is 2, 3 or 4 bytes long. A 3-byte pattern does not divide the word size, so its phase advances by one from each word to the next. The start bit doubles as the busy flag and drops by itself when the last beat is accepted. A separate done flag is raised at the same moment. While a fill is running, register writes and new start requests have no effect.

Top module: `mfill_engine`

## Requirements
- R1: After reset the engine is idle: control readback is 0, start, limit and pattern registers read 0, and `mem_valid` is low.
- R2: `reg_addr` selects 0 = first address, 1 = limit address, 2 = pattern, 3 = control. Control readback is bit 0 busy, bit 1 done, bit 8 and bit 9 the width bits as last written, other bits 0.
- R3: Writing control with bit 0 set while idle starts a fill. Busy reads 1 on the next cycle, and the first beat goes to the first address rounded down to a multiple of 4.
- R4: A beat at word address W enables lane i (bits 8i+7..8i) exactly when first <= W+i < limit.
- R5: With bit 8 = 0 and bit 9 = 0, the byte at address A is pattern[8k+7:8k] with k = (A - first) mod 2.
- R6: With bit 8 = 0 and bit 9 = 1, the byte at address A is pattern[8k+7:8k] with k = (A - first) mod 4.
- R7: With bit 8 = 1, the byte at address A is pattern[8k+7:8k] with k = (A - first) mod 3, so bytes [7:0], [15:8] and [23:16] repeat from the first address.
- R8: After the beat covering limit-1 is accepted, busy reads 0 and done reads 1 on the next cycle. An accepted start clears done.
- R9: If limit <= first, a start issues no beat, and done reads 1 with busy 0 on the next cycle.
- R10: Beats rise by 4 bytes, at most one is accepted per cycle, and address, data and enables hold while `mem_ready` is low.
- R11: While busy, writes to any register, a start request included, change nothing, even when they land in the cycle of the final beat.
- R12: Bit 8 takes priority over bit 9: with both set, the 3-byte pattern is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Word-aligned byte address of the beat |
| mem_wdata | output | 32 | Beat data |
| mem_be | output | 4 | Beat byte enables |

## Verification
Two functions can meet on one clock edge: the acceptance of the last beat, which clears busy, and a register write that asks for a new fill. The bench runs a one-word fill with ready held high and issues the start write and a second start write with different width bits back to back. The second write therefore lands on exactly the completing edge. It is judged correct when control then shows done with the first write's width bits, and when the scoreboard sees no further beat.

// File: rtl/mfill_pkg.sv
package mfill_pkg;

    typedef enum logic [1:0] {
        PAT16 = 2'd0,
        PAT24 = 2'd1,
        PAT32 = 2'd2
    } pat_e;

    localparam logic [1:0] SEL_FIRST = 2'd0;
    localparam logic [1:0] SEL_LIMIT = 2'd1;
    localparam logic [1:0] SEL_PAT   = 2'd2;
    localparam logic [1:0] SEL_CTRL  = 2'd3;

    localparam int CTL_GO  = 0;
    localparam int CTL_FIN = 1;
    localparam int CTL_W24 = 8;
    localparam int CTL_W32 = 9;

    // width bit 8 has priority over width bit 9
    function automatic pat_e decode_width(input logic w24, input logic w32);
        if (w24)      return PAT24;
        else if (w32) return PAT32;
        else          return PAT16;
    endfunction

    function automatic int unsigned pat_bytes(input pat_e m);
        case (m)
            PAT24:   return 3;
            PAT32:   return 4;
            default: return 2;
        endcase
    endfunction

    function automatic logic [1:0] wrap_idx(input int unsigned x, input pat_e m);
        return 2'(x % pat_bytes(m));
    endfunction

endpackage

// File: rtl/mfill_regs.sv
module mfill_regs
    import mfill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] limit_addr,
    output logic [DATA_W-1:0] pattern,
    output pat_e              width,
    output logic              go,
    output pat_e              go_width
);

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] limit;
        logic [DATA_W-1:0] pat;
        logic              w24;
        logic              w32;
    } regs_t;

    regs_t r_d, r_q;
    logic  go_d;
    logic [DATA_W-1:0] ctl_view;

    always_comb begin
        r_d  = r_q;
        go_d = 1'b0;
        if (reg_we && !busy) begin
            case (reg_addr)
                SEL_FIRST: r_d.first = reg_wdata[ADDR_W-1:0];
                SEL_LIMIT: r_d.limit = reg_wdata[ADDR_W-1:0];
                SEL_PAT:   r_d.pat   = reg_wdata;
                default: begin
                    r_d.w24 = reg_wdata[CTL_W24];
                    r_d.w32 = reg_wdata[CTL_W32];
                    go_d    = reg_wdata[CTL_GO];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        ctl_view          = '0;
        ctl_view[CTL_GO]  = busy;
        ctl_view[CTL_FIN] = done;
        ctl_view[CTL_W24] = r_q.w24;
        ctl_view[CTL_W32] = r_q.w32;
        case (reg_addr)
            SEL_FIRST: reg_rdata = DATA_W'(r_q.first);
            SEL_LIMIT: reg_rdata = DATA_W'(r_q.limit);
            SEL_PAT:   reg_rdata = r_q.pat;
            default:   reg_rdata = ctl_view;
        endcase
    end

    assign first_addr = r_q.first;
    assign limit_addr = r_q.limit;
    assign pattern    = r_q.pat;
    assign width      = decode_width(r_q.w24, r_q.w32);
    assign go         = go_d;
    assign go_width   = decode_width(reg_wdata[CTL_W24], reg_wdata[CTL_W32]);

endmodule

// File: rtl/mfill_seq.sv
module mfill_seq
    import mfill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  pat_e              go_width,
    input  pat_e              width,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] limit_addr,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        phase
);

    localparam int OFF_W = $clog2(LANES);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ADDR_W-1:0] cur;
        logic [1:0]        ph;
    } seq_t;

    seq_t s_d, s_q;
    int unsigned plen;
    int unsigned lead;
    logic        last_beat;

    always_comb begin
        s_d       = s_q;
        plen      = pat_bytes(go_width);
        lead      = int'(first_addr[OFF_W-1:0]) % plen;
        last_beat = ({1'b0, s_q.cur} + (ADDR_W+1)'(LANES)) >= {1'b0, limit_addr};
        if (go && !s_q.busy) begin
            s_d.done = 1'b0;
            if (limit_addr <= first_addr) begin
                s_d.done = 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.cur  = {first_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                // phase of lane 0 so that the first in-range lane gets index 0
                s_d.ph   = wrap_idx(plen - lead, go_width);
            end
        end else if (s_q.busy && mem_ready) begin
            if (last_beat) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cur = s_q.cur + ADDR_W'(LANES);
                s_d.ph  = wrap_idx(int'(s_q.ph) + LANES, width);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign cur_addr = s_q.cur;
    assign phase    = s_q.ph;

endmodule

// File: rtl/mfill_lanes.sv
module mfill_lanes
    import mfill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [1:0]        phase,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] limit_addr,
    input  logic [DATA_W-1:0] pattern,
    input  pat_e              width,
    output logic [DATA_W-1:0] lane_data,
    output logic [LANES-1:0]  lane_en
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [ADDR_W-1:0] byte_addr;
        logic [1:0]        idx;

        always_comb begin
            byte_addr          = cur_addr + ADDR_W'(i);
            idx                = wrap_idx(int'(phase) + i, width);
            lane_en[i]         = (byte_addr >= first_addr) && (byte_addr < limit_addr);
            lane_data[8*i +: 8] = pattern[8*idx +: 8];
        end
    end

endmodule

// File: rtl/mfill_engine.sv
module mfill_engine
    import mfill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W/8-1:0] mem_be
);

    localparam int LANES = DATA_W / 8;

    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] limit_addr;
    logic [DATA_W-1:0] pattern;
    pat_e              width;
    pat_e              go_width;
    logic              go;
    logic              busy;
    logic              done;
    logic [ADDR_W-1:0] cur_addr;
    logic [1:0]        phase;

    mfill_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .done       (done),
        .first_addr (first_addr),
        .limit_addr (limit_addr),
        .pattern    (pattern),
        .width      (width),
        .go         (go),
        .go_width   (go_width)
    );

    mfill_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .go_width   (go_width),
        .width      (width),
        .first_addr (first_addr),
        .limit_addr (limit_addr),
        .mem_ready  (mem_ready),
        .busy       (busy),
        .done       (done),
        .cur_addr   (cur_addr),
        .phase      (phase)
    );

    mfill_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .cur_addr   (cur_addr),
        .phase      (phase),
        .first_addr (first_addr),
        .limit_addr (limit_addr),
        .pattern    (pattern),
        .width      (width),
        .lane_data  (mem_wdata),
        .lane_en    (mem_be)
    );

    assign mem_valid = busy;
    assign mem_addr  = cur_addr;

endmodule

// File: rtl/mfill_chk.sv
module mfill_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [LANES-1:0]  mem_be,
    input logic              busy,
    input logic              done
);

    localparam int OFF_W = $clog2(LANES);

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be)); // R10

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> !mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(LANES))); // R10

    AST_BEAT_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_be != '0); // R4

    AST_BEAT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[OFF_W-1:0] == '0); // R3

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R8

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8

endmodule

bind mfill_engine mfill_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_mfill_engine.sv
module sim_mfill_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_valid;
    logic        mem_ready;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;

    always #4 clk = ~clk;

    mfill_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be)
    );

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
        string       req;
    } beat_t;

    beat_t exp_q[$];
    int    checks = 0;
    int    fails = 0;
    bit    stall_en = 1'b0;
    int    ctr = 0;
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every accepted beat, then updates ready
    always @(negedge clk) begin
        beat_t       b;
        logic [31:0] m;
        if (rst_n && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected beat at", mem_addr, 32'd0);
            end else begin
                b = exp_q.pop_front();
                m = {{8{b.be[3]}}, {8{b.be[2]}}, {8{b.be[1]}}, {8{b.be[0]}}};
                chk(mem_addr == b.addr, b.req, "beat address", mem_addr, b.addr);
                chk(mem_be == b.be, "R4", "byte enables", {28'd0, mem_be}, {28'd0, b.be});
                chk((mem_wdata & m) == (b.data & m), b.req, "beat data", mem_wdata & m, b.data & m);
            end
        end
        ctr++;
        mem_ready = !stall_en || ((ctr % 5) >= 2);
    end

    task automatic push_fill(input logic [31:0] s, input logic [31:0] e,
                             input logic [31:0] v, input logic [31:0] ctl, input string req);
        int p = ctl[8] ? 3 : (ctl[9] ? 4 : 2);
        bit first = 1'b1;
        for (longint w = longint'(s & 32'hFFFF_FFFC); w < longint'(e); w += 4) begin
            beat_t b;
            b.addr = 32'(w);
            b.be   = 4'd0;
            b.data = 32'd0;
            for (int i = 0; i < 4; i++) begin
                longint a = w + i;
                if (a >= longint'(s) && a < longint'(e)) begin
                    int k = int'(a - longint'(s)) % p;
                    b.be[i] = 1'b1;
                    b.data[8*i +: 8] = v[8*k +: 8];
                end
            end
            b.req = first ? "R3" : req;
            first = 1'b0;
            exp_q.push_back(b);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(output logic [31:0] r);
        r = 32'd0;
        for (int n = 0; n < 3000; n++) begin
            rd(2'd3, r);
            if (r[1]) break;
        end
    endtask

    task automatic run_fill(input logic [31:0] s, input logic [31:0] e,
                            input logic [31:0] v, input logic [31:0] ctl, input string req);
        logic [31:0] r;
        wr(2'd0, s);
        wr(2'd1, e);
        wr(2'd2, v);
        push_fill(s, e, v, ctl, req);
        wr(2'd3, ctl | 32'd1);
        rd(2'd3, r);
        chk(r[0] == 1'b1, "R3", "busy after start", {31'd0, r[0]}, 32'd1);
        chk(r[1] == 1'b0, "R8", "done cleared by start", {31'd0, r[1]}, 32'd0);
        wait_done(r);
        chk(r == ((ctl & 32'h300) | 32'h2), "R8", "control after fill", r, (ctl & 32'h300) | 32'h2);
        chk(exp_q.size() == 0, req, "beats left over", exp_q.size(), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not end actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd3, r);
        chk(r == 32'd0, "R1", "control at reset", r, 32'd0);
        chk(mem_valid == 1'b0, "R1", "valid at reset", {31'd0, mem_valid}, 32'd0);
        rd(2'd0, r);
        chk(r == 32'd0, "R1", "first address at reset", r, 32'd0);
        rd(2'd2, r);
        chk(r == 32'd0, "R1", "pattern at reset", r, 32'd0);

        // R2 control layout, width bits without start
        wr(2'd3, 32'h0000_0300);
        rd(2'd3, r);
        chk(r == 32'h0000_0300, "R2", "control readback", r, 32'h0000_0300);
        rd(2'd3, r);
        chk(mem_valid == 1'b0, "R2", "no start without bit 0", {31'd0, mem_valid}, 32'd0);

        // R5 two-byte pattern with stalls
        stall_en = 1'b1;
        run_fill(32'h0000_0101, 32'h0000_010B, 32'hBEEF_CAFE, 32'h0, "R5");
        run_fill(32'h0000_0120, 32'h0000_0126, 32'h1234_5678, 32'h0, "R5");
        // R6 four-byte pattern
        run_fill(32'h0000_0202, 32'h0000_0213, 32'h1122_3344, 32'h200, "R6");
        // R7 three-byte pattern, each lead offset
        run_fill(32'h0000_0301, 32'h0000_031A, 32'hAA33_2211, 32'h100, "R7");
        run_fill(32'h0000_0400, 32'h0000_040C, 32'h00C3_B2A1, 32'h100, "R7");
        run_fill(32'h0000_0442, 32'h0000_0451, 32'h0066_5544, 32'h100, "R7");
        run_fill(32'h0000_0483, 32'h0000_0490, 32'h0099_8877, 32'h100, "R7");
        // R12 both width bits set picks three bytes
        run_fill(32'h0000_0503, 32'h0000_0509, 32'hDD0C_0B0A, 32'h300, "R12");

        // R9 empty range: equal, then reversed
        wr(2'd0, 32'h0000_0080);
        wr(2'd1, 32'h0000_0080);
        wr(2'd3, 32'h0000_0001);
        rd(2'd3, r);
        chk(r == 32'h2, "R9", "equal bounds complete at once", r, 32'h2);
        wr(2'd0, 32'h0000_0090);
        wr(2'd1, 32'h0000_0010);
        wr(2'd3, 32'h0000_0201);
        rd(2'd3, r);
        chk(r == 32'h202, "R9", "reversed bounds complete at once", r, 32'h202);
        repeat (3) @(negedge clk);
        chk(mem_valid == 1'b0, "R9", "no beat for empty range", {31'd0, mem_valid}, 32'd0);

        // R11 register writes while busy
        wr(2'd0, 32'h0000_0600);
        wr(2'd1, 32'h0000_063D);
        wr(2'd2, 32'h0A0B_0C0D);
        push_fill(32'h0000_0600, 32'h0000_063D, 32'h0A0B_0C0D, 32'h0, "R11");
        wr(2'd3, 32'h0000_0001);
        wr(2'd0, 32'h0000_0999);
        wr(2'd1, 32'h0000_9999);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd3, 32'h0000_0101);
        rd(2'd0, r);
        chk(r == 32'h0000_0600, "R11", "first address held", r, 32'h0000_0600);
        rd(2'd1, r);
        chk(r == 32'h0000_063D, "R11", "limit held", r, 32'h0000_063D);
        rd(2'd2, r);
        chk(r == 32'h0A0B_0C0D, "R11", "pattern held", r, 32'h0A0B_0C0D);
        rd(2'd3, r);
        chk(r == 32'h0000_0001, "R11", "control held while busy", r, 32'h0000_0001);
        wait_done(r);
        chk(r == 32'h2, "R11", "control after busy writes", r, 32'h2);
        chk(exp_q.size() == 0, "R11", "beats left over", exp_q.size(), 32'd0);

        // R11 / R8 start request landing on the completing edge
        stall_en = 1'b0;
        repeat (2) @(negedge clk);
        wr(2'd0, 32'h0000_0700);
        wr(2'd1, 32'h0000_0704);
        wr(2'd2, 32'h5566_7788);
        push_fill(32'h0000_0700, 32'h0000_0704, 32'h5566_7788, 32'h200, "R6");
        wr(2'd3, 32'h0000_0201);
        wr(2'd3, 32'h0000_0101);
        wait_done(r);
        chk(r == 32'h0000_0202, "R11", "start on final edge ignored", r, 32'h0000_0202);
        repeat (4) @(negedge clk);
        chk(mem_valid == 1'b0, "R11", "no beat after final edge", {31'd0, mem_valid}, 32'd0);
        chk(exp_q.size() == 0, "R8", "beats left over", exp_q.size(), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule